// File: doc/BRIEF.md
# External Interrupt Pending Controller

This block watches 28 asynchronous interrupt pins, numbered 0 to 27, and turns trigger events on them into sticky pending bits. Software sets the trigger condition of each pin through two packed configuration words, blocks or passes individual sources through a mask word, and acknowledges events by writing ones to the pending word. The pins are grouped into four request lines for a downstream vectored interrupt controller. Each line covers one range of pins: 0–3, 4–11, 12–19 and 20–27.

Every pin goes through a two-flop synchroniser. Edge triggers compare the synchronised sample with the sample from the cycle before. A level trigger sets its pending bit again on every cycle that the active level is present, so an acknowledge has a lasting effect only after the pin has gone inactive. Access is through a plain register bus with a word address, a write strobe, write data and combinational read data. The interface has no stream traffic, so it has no valid/ready pins and no back-pressure.

Top module: `xint_pend_ctrl`

## Requirements
- R1: After reset, the mask word reads 0x0FFFFFFF, the pending word reads 0, both configuration words read 0 and all four group outputs are low.
- R2: A pin change reaches the pending word three rising clock edges after the edge at which it is first sampled: two synchroniser stages, then the pending register.
- R3: Trigger codes: 000 sets pending while the pin is low, 001 while it is high, 01x on a falling edge, 10x on a rising edge and 11x on either edge. A pending bit set by an edge stays set until it is cleared.
- R4: Configuration word 0 (address 0) serves sources 0–15 and word 1 (address 1) serves sources 16–27. Source n uses the 3-bit field at bit (n/2)*4 of its word (for word 1, (n-16)/2*4), so each even/odd pair shares one field. Bit 3 of each field is not stored and reads 0.
- R5: Bits 24–31 of configuration word 1 would address sources above 27. Writes to them have no effect and they read 0.
- R6: The mask word is at address 2, and bit n set to 1 blocks source n from the group outputs. Bits 28–31 read 0.
- R7: The pending word is at address 3. Writing it clears exactly the bits written as 1. A read returns the raw pending bits whatever the mask holds, and bits 28–31 read 0.
- R8: In a level mode the pending bit is set again every cycle that the level is active. A set wins over a clear written in the same cycle.
- R9: Group output g is high when any pending and unmasked bit lies in its range: 0–3, 4–11, 12–19 or 20–27.
- R10: Writes to addresses 4–7 change no state, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_i | input | 28 | Asynchronous interrupt pins |
| grp_irq_o | output | 4 | Group request lines |

## Verification
The assertions assume the pins and the bus are stable around each rising clock edge. They also assume reset is held for at least one edge, so that the synchroniser check's two-cycle look-back only ever sees samples taken after reset. The bench drives every input on the falling edge and keeps reset low for several cycles. Random pin patterns and random writes to all eight addresses are mixed with directed sequences for each trigger code, and for a clear that collides with an active level.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd3;

  localparam int unsigned CODE_W  = 3;
  localparam int unsigned SLOT_W  = 4;

  // decide whether one source fires this cycle
  function automatic logic trig_hit(input logic [CODE_W-1:0] code,
                                    input logic cur, input logic prev);
    logic r;
    unique case (code[2:1])
      2'b00:   r = code[0] ? cur : ~cur;
      2'b01:   r = prev & ~cur;
      2'b10:   r = ~prev & cur;
      default: r = prev ^ cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= async_i;
      stg2_q <= stg1_q;
    end
  end

  assign sync_o = stg2_q;

  // cycles since reset, saturating, so the look-back never crosses reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
#(
  parameter int unsigned NUM_SRC = 28,
  localparam int unsigned NUM_FLD = (NUM_SRC + 1) / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        cur_i,
  input  logic [NUM_FLD*CODE_W-1:0] fld_i,
  output logic [NUM_SRC-1:0]        hit_o
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int unsigned FI = n / 2;
    assign hit_o[n] = trig_hit(fld_i[FI*CODE_W +: CODE_W], cur_i[n], prev_q[n]);
  end
endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter int unsigned NUM_SRC = 28,
  localparam int unsigned NUM_FLD = (NUM_SRC + 1) / 2,
  localparam int unsigned FPR     = DW / SLOT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  input  logic [NUM_SRC-1:0]        hit_i,
  output logic [NUM_FLD*CODE_W-1:0] fld_o,
  output logic [NUM_SRC-1:0]        mask_o,
  output logic [NUM_SRC-1:0]        pend_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] clr_vec;

  // one field per source pair, placed in word k/FPR at slot k%FPR
  for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
    localparam int unsigned RIDX = k / FPR;
    localparam int unsigned SLOT = k % FPR;
    localparam logic [ADDR_W-1:0] FADDR = A_CFG0 + ADDR_W'(RIDX);
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            code_q <= '0;
      else if (bus_wr && bus_addr == FADDR)  code_q <= bus_wdata[SLOT*SLOT_W +: CODE_W];
    end
    assign fld_o[k*CODE_W +: CODE_W] = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            mask_q <= '1;
    else if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NUM_SRC-1:0];
  end

  assign clr_vec = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NUM_SRC-1:0] : '0;

  // a new event wins over an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | hit_i;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CFG0, A_CFG1: begin
        for (int j = 0; j < int'(FPR); j++) begin
          if ((int'(bus_addr - A_CFG0) * int'(FPR) + j) < int'(NUM_FLD))
            bus_rdata[j*SLOT_W +: CODE_W] =
              fld_o[(int'(bus_addr - A_CFG0) * int'(FPR) + j) * CODE_W +: CODE_W];
        end
      end
      A_MASK:  bus_rdata[NUM_SRC-1:0] = mask_q;
      A_PEND:  bus_rdata[NUM_SRC-1:0] = pend_q;
      default: bus_rdata = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  // R7: a pending bit only drops where a one was written to the pending word
  a_r7_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~pend_q & $past(pend_q) & ~$past(clr_vec)) == '0));

  // R8: every detected event shows up as pending on the next cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(hit_i) & ~pend_q) == '0));
endmodule

// File: rtl/xint_group.sv
module xint_group #(
  parameter int unsigned NUM_SRC = 28,
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned FIRST_W = 4,
  parameter int unsigned GRP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_GRP-1:0] grp_o
);
  logic [NUM_SRC-1:0] live;
  assign live = pend_i & ~mask_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned LO = (g == 0) ? 0 : FIRST_W + (g - 1) * GRP_W;
    localparam int unsigned HI = FIRST_W + g * GRP_W - 1;
    assign grp_o[g] = |live[HI:LO];

    // R9: a raised line needs at least one unmasked source in its range
    a_r9_grp_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      grp_o[g] |-> !(&mask_i[HI:LO]));
  end
endmodule

// File: rtl/xint_pend_ctrl.sv
module xint_pend_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned NUM_SRC = 28,
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned FIRST_W = 4,
  parameter int unsigned GRP_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NUM_SRC-1:0]  pin_i,
  output logic [NUM_GRP-1:0]  grp_irq_o
);
  localparam int unsigned NUM_FLD = (NUM_SRC + 1) / 2;
  localparam int unsigned FPR     = DW / SLOT_W;
  localparam int unsigned HI_USED = (NUM_FLD - FPR) * SLOT_W;

  logic [NUM_SRC-1:0]        cur;
  logic [NUM_SRC-1:0]        hit;
  logic [NUM_FLD*CODE_W-1:0] fld;
  logic [NUM_SRC-1:0]        mask;
  logic [NUM_SRC-1:0]        pend;

  xint_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(cur));

  xint_detect #(.NUM_SRC(NUM_SRC)) u_det (
    .clk(clk), .rst_n(rst_n), .cur_i(cur), .fld_i(fld), .hit_o(hit));

  xint_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit_i(hit),
    .fld_o(fld), .mask_o(mask), .pend_o(pend));

  xint_group #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .FIRST_W(FIRST_W),
               .GRP_W(GRP_W)) u_grp (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .grp_o(grp_irq_o));

  // R5: slots above the last source pair read as zero
  a_r5_cfg_hi_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CFG1) |-> ((bus_rdata >> HI_USED) == '0));

  // R6/R7: bits beyond the last source read as zero
  a_r6_word_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MASK || bus_addr == A_PEND) |-> ((bus_rdata >> NUM_SRC) == '0));

  // R10: unused addresses read zero
  a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > A_PEND) |-> (bus_rdata == '0));
endmodule

// File: tb/xint_pend_ctrl_bench.sv
module xint_pend_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int NS = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] pin_i = '0;
  logic [3:0]  grp_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  xint_pend_ctrl u_xint_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .grp_irq_o(grp_irq_o));

  // reference model built from the requirements
  logic [NS-1:0] m_s1, m_s2, m_prev, m_mask, m_pend;
  logic [2:0]    m_code [14];

  function automatic logic m_fire(logic [2:0] c, logic now, logic old);
    if (c == 3'b000) return !now;            // R3 low level
    if (c == 3'b001) return now;             // R3 high level
    if (c[2:1] == 2'b01) return old && !now; // falling
    if (c[2:1] == 2'b10) return !old && now; // rising
    return old != now;                       // both
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_mask <= '1; m_pend <= '0;
      for (int k = 0; k < 14; k++) m_code[k] <= 3'b000;
    end else begin
      logic [NS-1:0] ev;
      logic [NS-1:0] clr;
      for (int n = 0; n < NS; n++) ev[n] = m_fire(m_code[n/2], m_s2[n], m_prev[n]);
      clr = (bus_wr && bus_addr == 3'd3) ? bus_wdata[NS-1:0] : '0;
      m_pend <= (m_pend & ~clr) | ev;
      m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
      if (bus_wr && bus_addr == 3'd2) m_mask <= bus_wdata[NS-1:0];
      if (bus_wr && bus_addr == 3'd0)
        for (int k = 0; k < 8; k++) m_code[k] <= bus_wdata[k*4 +: 3];
      if (bus_wr && bus_addr == 3'd1)
        for (int k = 0; k < 6; k++) m_code[8+k] <= bus_wdata[k*4 +: 3];
    end
  end

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    logic [31:0] r = '0;
    case (a)
      3'd0: for (int k = 0; k < 8; k++) r[k*4 +: 3] = m_code[k];
      3'd1: for (int k = 0; k < 6; k++) r[k*4 +: 3] = m_code[8+k];
      3'd2: r[NS-1:0] = m_mask;
      3'd3: r[NS-1:0] = m_pend;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] exp_grp();
    logic [NS-1:0] l = m_pend & ~m_mask;
    return {|l[27:20], |l[19:12], |l[11:4], |l[3:0]};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, bus_rdata, exp_rd(bus_addr));
    check("R9", {28'd0, grp_irq_o}, {28'd0, exp_grp()});
  endtask

  // one bus cycle: drive at negedge, check at next negedge
  task automatic cyc(logic [2:0] a, logic w, logic [31:0] d, string tag);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    int cyc_cnt = 0;
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d cycles expected < 150000", cyc_cnt);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    string tg;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    // R1 reset values
    bus_addr = 3'd2; #1 check("R1", bus_rdata, 32'h0FFF_FFFF);
    bus_addr = 3'd3; #1 check("R1", bus_rdata, 32'h0);
    bus_addr = 3'd0; #1 check("R1", bus_rdata, 32'h0);
    bus_addr = 3'd1; #1 check("R1", bus_rdata, 32'h0);
    check("R1", {28'd0, grp_irq_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R5 reserved upper slots of word 1
    cyc(3'd1, 1'b1, 32'hFFFF_FFFF, "R5");
    check("R5", bus_rdata, 32'h0077_7777);
    // R4 bit 3 of each slot not stored
    cyc(3'd0, 1'b1, 32'hFFFF_FFFF, "R4");
    check("R4", bus_rdata, 32'h7777_7777);

    // R2/R3 rising edge on source 5 (field 2 of word 0 = 100)
    cyc(3'd0, 1'b1, 32'h0000_0400, "R4");
    cyc(3'd1, 1'b1, 32'h0, "R4");
    cyc(3'd2, 1'b1, 32'h0FFF_FFDF, "R6");
    cyc(3'd3, 1'b1, 32'hFFFF_FFFF, "R8");   // low-level pins still re-set
    pin_i[5] = 1'b1;
    cyc(3'd3, 1'b0, 0, "R2");
    cyc(3'd3, 1'b0, 0, "R2");
    cyc(3'd3, 1'b0, 0, "R2");
    check("R3", {31'd0, bus_rdata[5]}, 32'd1);
    check("R9", {31'd0, grp_irq_o[1]}, 32'd1);
    pin_i[5] = 1'b0;
    repeat (4) cyc(3'd3, 1'b0, 0, "R3");
    check("R3", {31'd0, bus_rdata[5]}, 32'd1);   // sticky after rising edge
    cyc(3'd3, 1'b1, 32'h0000_0020, "R7");
    check("R7", {31'd0, bus_rdata[5]}, 32'd0);

    // R8 high level on source 20 (word 1 slot 2 = 001), clear during level
    cyc(3'd1, 1'b1, 32'h0000_0100, "R4");
    pin_i[20] = 1'b1;
    repeat (3) cyc(3'd3, 1'b0, 0, "R8");
    cyc(3'd3, 1'b1, 32'h0010_0000, "R8");
    check("R8", {31'd0, bus_rdata[20]}, 32'd1);
    pin_i[20] = 1'b0;
    repeat (3) cyc(3'd3, 1'b0, 0, "R8");
    cyc(3'd3, 1'b1, 32'h0010_0000, "R8");
    check("R8", {31'd0, bus_rdata[20]}, 32'd0);

    // R10 unused addresses
    cyc(3'd5, 1'b1, 32'hFFFF_FFFF, "R10");
    cyc(3'd2, 1'b0, 0, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  a = 3'($urandom_range(0, 7));
      logic        w = ($urandom_range(0, 3) == 0);
      logic [31:0] d = $urandom();
      if ($urandom_range(0, 2) == 0) pin_i = NS'($urandom());
      if (a == 3'd3 && w) d = d & $urandom();
      case (a)
        3'd0, 3'd1: tg = "R4";
        3'd2: tg = "R6";
        3'd3: tg = "R7";
        default: tg = "R10";
      endcase
      cyc(a, w, d, tg);
      if (i % 7 == 0) begin
        bus_addr = 3'd3; #1 check("R3", bus_rdata, exp_rd(3'd3));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule